// File: doc/BRIEF.md
# Shared-Bus Byte Datapath

This block is the register-transfer core of a small 8-bit processor. Every storage element hangs off one internal byte-wide bus. An outside controller raises one-hot strobes: a load strobe makes a unit capture the bus on the next rising clock edge, and a drive strobe makes a unit place its contents on the bus during the current cycle. The units are two operand registers, an instruction register, a free-running adder, a loadable and countable program counter, a memory address register and a sixteen-byte scratch memory. An external port can also supply the bus value, so a controller or debugger can preload registers and memory before any program runs.

The bus is built as an AND-OR selector rather than with tri-state drivers. With no source enabled it reads zero. It is exported as `bus_val` so that the state of every unit can be observed by enabling that unit's drive strobe.

Top module: `sbd_datapath`

## Requirements
- R1: A cycle with `rst_n` low clears the operand registers, the instruction register, the program counter and the address register to zero at the next rising edge. Each of them then reads 0x00 when driven.
- R2: `bus_val` equals the contents of whichever single source has its drive strobe high. With `ext_oe` high and no unit drive strobe set, it equals `ext_data`. With nothing enabled it is 0x00. At most one of the seven drive enables may be high in a cycle.
- R3: Each register captures `bus_val` at a rising edge only when its load strobe is high, and holds its value otherwise.
- R4: Driving the instruction register puts its low 4 bits on bus bits 3:0 and zero on bits 7:4 (a stored 0xCC reads back as 0x0C).
- R5: Driving the adder puts the sum of the two operand registers on the bus, modulo 256 (0xAA + 0xBB reads 0x65). It follows register changes with no extra cycle.
- R6: A memory write stores `bus_val` at the location held in the address register. A memory read drives the byte at that location.
- R7: The address register takes bus bits 3:0. After it is changed, a memory read returns the new location's byte and not the byte written before.
- R8: A program counter load takes bus bits 3:0 (0x2B loads 0xB). Driving the counter puts it on the bus zero-extended.
- R9: With `pc_inc` high and `ld_pc` low, the program counter advances by one per clock and wraps from 0xF to 0x0.
- R10: When `ld_pc` and `pc_inc` are both high, the load wins.
- R11: Reset leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all loads on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_a | input | 1 | Load operand register A from bus |
| ld_b | input | 1 | Load operand register B from bus |
| ld_ir | input | 1 | Load instruction register from bus |
| ld_ram | input | 1 | Write bus into memory at address register |
| ld_pc | input | 1 | Load program counter from bus |
| ld_mar | input | 1 | Load address register from bus |
| oe_a | input | 1 | Drive register A onto bus |
| oe_b | input | 1 | Drive register B onto bus |
| oe_ir | input | 1 | Drive instruction register low nibble onto bus |
| oe_alu | input | 1 | Drive adder result onto bus |
| oe_ram | input | 1 | Drive addressed memory byte onto bus |
| oe_pc | input | 1 | Drive program counter onto bus |
| pc_inc | input | 1 | Advance program counter |
| ext_oe | input | 1 | External port drives the bus |
| ext_data | input | 8 | External bus value |
| bus_val | output | 8 | Current value of the shared bus |

## Verification
The hardest case to reach is a memory read after the address register has moved. Observing it needs two different locations filled with distinct bytes, and every write, address change and readback has to pass through the single bus in separate cycles. The stimulus first writes one byte at address 0 and another at address 1. It then reloads the address register with a value whose upper nibble is non-zero and reads the memory. A second reset with the address back at zero checks that the first byte survived. The transfer path, where A drives the bus while B loads, is also exercised and observed through the adder.

// File: rtl/sbd_pkg.sv
// Package: shared widths and bus source indices for the shared-bus datapath.
// Assumes: a byte-wide bus and a 16-entry memory by default.
package sbd_pkg;
    localparam int SBD_DATA_W  = 8;
    localparam int SBD_ADDR_W  = 4;
    localparam int SBD_PC_W    = 4;
    localparam int SBD_IRLO_W  = 4;

    // Positions of each bus source in the selector
    localparam int SRC_A   = 0;
    localparam int SRC_B   = 1;
    localparam int SRC_IR  = 2;
    localparam int SRC_ALU = 3;
    localparam int SRC_RAM = 4;
    localparam int SRC_PC  = 5;
    localparam int SRC_EXT = 6;
    localparam int SRC_N   = 7;
endpackage

// File: rtl/sbd_load_reg.sv
// Module: plain register with a load enable and a synchronous active-low clear.
// Assumes: the load strobe is sampled on the rising edge.
module sbd_load_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d when loaded, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (ld) q <= d;
    end
endmodule

// File: rtl/sbd_pc.sv
// Module: program counter that can load and count, and wraps at its width.
// Assumes: when both strobes are set, the load takes priority over counting.
module sbd_pc #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         inc,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Load, else count, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (ld)  q <= d;
        else if (inc) q <= q + W'(1);
    end
endmodule

// File: rtl/sbd_ram.sv
// Module: small memory with one synchronous write port and an asynchronous read.
// Assumes: contents are never cleared, and writes are blocked while reset is low.
module sbd_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write the bus byte at the addressed location
    always_ff @(posedge clk) begin
        if (rst_n && we) mem[addr] <= wdata;
    end

    // Read the addressed location combinationally
    always_comb rdata = mem[addr];
endmodule

// File: rtl/sbd_bus_mux.sv
// Module: AND-OR bus selector standing in for tri-state drivers.
// Assumes: the enables are one-hot or all zero. All zero gives zero on the bus.
module sbd_bus_mux #(
    parameter int DATA_W = 8,
    parameter int N      = 7
) (
    input  logic [N-1:0]      sel,
    input  logic [DATA_W-1:0] src [N],
    output logic [DATA_W-1:0] bus
);
    logic [DATA_W-1:0] gated [N];

    // Gate every source by its own enable
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = sel[i] ? src[i] : '0;
    end

    // OR the gated sources together
    always_comb begin
        bus = '0;
        for (int i = 0; i < N; i++) bus = bus | gated[i];
    end
endmodule

// File: rtl/sbd_datapath.sv
// Module: shared-bus byte datapath. Each unit loads from or drives one internal bus
// under external one-hot strobes.
// Assumes: at most one drive enable per cycle, and a synchronous active-low reset.
module sbd_datapath
    import sbd_pkg::*;
#(
    parameter int DATA_W = SBD_DATA_W,
    parameter int ADDR_W = SBD_ADDR_W,
    parameter int PC_W   = SBD_PC_W,
    parameter int IRLO_W = SBD_IRLO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              ld_ir,
    input  logic              ld_ram,
    input  logic              ld_pc,
    input  logic              ld_mar,
    input  logic              oe_a,
    input  logic              oe_b,
    input  logic              oe_ir,
    input  logic              oe_alu,
    input  logic              oe_ram,
    input  logic              oe_pc,
    input  logic              pc_inc,
    input  logic              ext_oe,
    input  logic [DATA_W-1:0] ext_data,
    output logic [DATA_W-1:0] bus_val
);
    logic [DATA_W-1:0] a_q, b_q, alu_sum, ram_rd;
    logic [IRLO_W-1:0] ir_q;
    logic [ADDR_W-1:0] mar_q;
    logic [PC_W-1:0]   pc_q;
    logic [SRC_N-1:0]  src_sel;
    logic [DATA_W-1:0] src_val [SRC_N];

    // Operand registers
    sbd_load_reg #(.W(DATA_W)) u_reg_a (.clk(clk), .rst_n(rst_n), .ld(ld_a), .d(bus_val), .q(a_q));
    sbd_load_reg #(.W(DATA_W)) u_reg_b (.clk(clk), .rst_n(rst_n), .ld(ld_b), .d(bus_val), .q(b_q));

    // Instruction register keeps only the visible operand nibble
    sbd_load_reg #(.W(IRLO_W)) u_reg_ir (.clk(clk), .rst_n(rst_n), .ld(ld_ir),
                                         .d(bus_val[IRLO_W-1:0]), .q(ir_q));

    // Memory address register
    sbd_load_reg #(.W(ADDR_W)) u_reg_mar (.clk(clk), .rst_n(rst_n), .ld(ld_mar),
                                          .d(bus_val[ADDR_W-1:0]), .q(mar_q));

    // Program counter
    sbd_pc #(.W(PC_W)) u_pc (.clk(clk), .rst_n(rst_n), .ld(ld_pc), .inc(pc_inc),
                             .d(bus_val[PC_W-1:0]), .q(pc_q));

    // Scratch memory
    sbd_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ld_ram), .addr(mar_q),
        .wdata(bus_val), .rdata(ram_rd)
    );

    // Adder follows the operand registers, carry out dropped
    always_comb alu_sum = a_q + b_q;

    // Collect bus sources and their enables
    always_comb begin
        src_sel          = '0;
        src_sel[SRC_A]   = oe_a;
        src_sel[SRC_B]   = oe_b;
        src_sel[SRC_IR]  = oe_ir;
        src_sel[SRC_ALU] = oe_alu;
        src_sel[SRC_RAM] = oe_ram;
        src_sel[SRC_PC]  = oe_pc;
        src_sel[SRC_EXT] = ext_oe;
        src_val[SRC_A]   = a_q;
        src_val[SRC_B]   = b_q;
        src_val[SRC_IR]  = {{(DATA_W-IRLO_W){1'b0}}, ir_q};
        src_val[SRC_ALU] = alu_sum;
        src_val[SRC_RAM] = ram_rd;
        src_val[SRC_PC]  = {{(DATA_W-PC_W){1'b0}}, pc_q};
        src_val[SRC_EXT] = ext_data;
    end

    // Shared bus selector
    sbd_bus_mux #(.DATA_W(DATA_W), .N(SRC_N)) u_bus (.sel(src_sel), .src(src_val), .bus(bus_val));
endmodule

// File: rtl/sbd_datapath_chk.sv
// Module: property checker for the shared-bus datapath, attached to it by bind.
// Assumes: it is observed from the top's ports and internal register outputs.
module sbd_datapath_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int PC_W   = 4,
    parameter int IRLO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_a,
    input logic              ld_ram,
    input logic              ld_pc,
    input logic              pc_inc,
    input logic [6:0]        oe_vec,
    input logic              oe_ir,
    input logic              oe_ram,
    input logic [DATA_W-1:0] bus_val,
    input logic [DATA_W-1:0] a_q,
    input logic [DATA_W-1:0] b_q,
    input logic [IRLO_W-1:0] ir_q,
    input logic [ADDR_W-1:0] mar_q,
    input logic [PC_W-1:0]   pc_q
);
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (a_q == '0 && b_q == '0 && ir_q == '0 && pc_q == '0 && mar_q == '0));

    assert_single_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oe_vec));

    assert_load_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_a)) |-> a_q == $past(bus_val));

    assert_hold_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_a)) |-> $stable(a_q));

    assert_ir_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ir |-> bus_val[DATA_W-1:IRLO_W] == '0);

    assert_ram_readback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_ram) && mar_q == $past(mar_q) && oe_ram)
            |-> bus_val == $past(bus_val));

    assert_pc_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pc_inc) && !$past(ld_pc)) |-> pc_q == PC_W'($past(pc_q) + 1'b1));

    assert_pc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ld_pc)) |-> pc_q == $past(bus_val[PC_W-1:0]));
endmodule

bind sbd_datapath sbd_datapath_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PC_W(PC_W), .IRLO_W(IRLO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .ld_ram(ld_ram), .ld_pc(ld_pc), .pc_inc(pc_inc),
    .oe_vec({oe_a, oe_b, oe_ir, oe_alu, oe_ram, oe_pc, ext_oe}),
    .oe_ir(oe_ir), .oe_ram(oe_ram), .bus_val(bus_val),
    .a_q(a_q), .b_q(b_q), .ir_q(ir_q), .mar_q(mar_q), .pc_q(pc_q)
);

// File: tb/sbd_datapath_tb.sv
`timescale 1ns/1ps
// Bench: scoreboard for the shared-bus datapath. A driver queues the expected bus
// value of each checked cycle, and a monitor compares at the falling edge.
module sbd_datapath_tb;
    // Strobe vector bit positions
    localparam int LA = 0, LB = 1, LIR = 2, LRAM = 3, LPC = 4, LMAR = 5;
    localparam int OA = 6, OB = 7, OIR = 8, OALU = 9, ORAM = 10, OPC = 11, INC = 12, EXT = 13;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ctl = '0;
    logic [7:0]  ext_data = '0;
    logic [7:0]  bus_val;
    item_t       sb_q[$];
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sbd_datapath u_dut (
        .clk(clk), .rst_n(rst_n),
        .ld_a(ctl[LA]), .ld_b(ctl[LB]), .ld_ir(ctl[LIR]), .ld_ram(ctl[LRAM]),
        .ld_pc(ctl[LPC]), .ld_mar(ctl[LMAR]),
        .oe_a(ctl[OA]), .oe_b(ctl[OB]), .oe_ir(ctl[OIR]), .oe_alu(ctl[OALU]),
        .oe_ram(ctl[ORAM]), .oe_pc(ctl[OPC]), .pc_inc(ctl[INC]), .ext_oe(ctl[EXT]),
        .ext_data(ext_data), .bus_val(bus_val)
    );

    // Apply one cycle of strobes just after the rising edge, queueing an expectation if asked
    task automatic step(input logic [13:0] s, input logic [7:0] ed,
                        input bit chk, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        ctl      = s;
        ext_data = ed;
        if (chk) begin
            it.exp = exp;
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    function automatic logic [13:0] b(input int i);
        return 14'(1) << i;
    endfunction

    // Monitor: compare the bus against the queued expectation at mid-cycle
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            total++;
            if (bus_val !== it.exp) begin
                bad++;
                $display("FAIL %s: bus=%02h expected=%02h", it.tag, bus_val, it.exp);
            end
        end
    end

    // Watchdog
    initial begin
        #(100000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        step('0, 8'h00, 0, 0, "");
        step('0, 8'h00, 0, 0, "");
        @(posedge clk); #1; rst_n = 1'b1; ctl = '0;
        // R1: reset state read back through each driver
        step(b(OA),   8'h00, 1, 8'h00, "R1 A");
        step(b(OB),   8'h00, 1, 8'h00, "R1 B");
        step(b(OIR),  8'h00, 1, 8'h00, "R1 IR");
        step(b(OPC),  8'h00, 1, 8'h00, "R1 PC");
        step(b(OALU), 8'h00, 1, 8'h00, "R1 ALU");
        step('0,      8'h99, 1, 8'h00, "R2 idle bus");
        // Preload through the external port
        step(b(EXT) | b(LMAR), 8'h00, 0, 0, "");
        step(b(EXT) | b(LPC),  8'h04, 0, 0, "");
        step(b(EXT) | b(LA),   8'hAA, 0, 0, "");
        step(b(EXT) | b(LB),   8'hBB, 0, 0, "");
        step(b(EXT) | b(LIR),  8'hCC, 0, 0, "");
        step(b(EXT) | b(LRAM), 8'hDD, 1, 8'hDD, "R2 ext drive");
        step(b(OA),   8'h00, 1, 8'hAA, "R3 A load");
        step(b(OB),   8'h00, 1, 8'hBB, "R3 B load");
        step(b(OIR),  8'h00, 1, 8'h0C, "R4 IR nibble");
        step(b(OALU), 8'h00, 1, 8'h65, "R5 sum wrap");
        step(b(OPC),  8'h00, 1, 8'h04, "R8 PC drive");
        step(b(ORAM), 8'h00, 1, 8'hDD, "R6 RAM read");
        // R7: second location, move address, read back both
        step(b(EXT) | b(LMAR), 8'h01, 0, 0, "");
        step(b(EXT) | b(LRAM), 8'h33, 0, 0, "");
        step(b(EXT) | b(LMAR), 8'h00, 0, 0, "");
        step(b(ORAM), 8'h00, 1, 8'hDD, "R6 addr0");
        step(b(EXT) | b(LMAR), 8'hF1, 0, 0, "");
        step(b(ORAM), 8'h00, 1, 8'h33, "R7 moved addr");
        // R3 hold: bus activity without load strobe
        step(b(EXT), 8'h77, 1, 8'h77, "R2 ext");
        step(b(OA),  8'h00, 1, 8'hAA, "R3 A hold");
        // Transfer A into B, observe through the adder
        step(b(OA) | b(LB), 8'h00, 1, 8'hAA, "R3 transfer");
        step(b(OALU), 8'h00, 1, 8'h54, "R5 A+A");
        step(b(EXT) | b(LIR), 8'h3F, 0, 0, "");
        step(b(OIR), 8'h00, 1, 8'h0F, "R4 IR 3F");
        // PC load with high bits, counting and wrap
        step(b(EXT) | b(LPC), 8'h2B, 0, 0, "");
        step(b(OPC), 8'h00, 1, 8'h0B, "R8 nibble");
        step(b(EXT) | b(LPC), 8'h0E, 0, 0, "");
        step(b(INC), 8'h00, 0, 0, "");
        step(b(OPC), 8'h00, 1, 8'h0F, "R9 count");
        step(b(INC), 8'h00, 0, 0, "");
        step(b(OPC), 8'h00, 1, 8'h00, "R9 wrap");
        step(b(EXT) | b(LPC) | b(INC), 8'h07, 0, 0, "");
        step(b(OPC), 8'h00, 1, 8'h07, "R10 load wins");
        // Second reset: registers clear, memory kept
        @(posedge clk); #1; rst_n = 1'b0; ctl = '0;
        @(posedge clk); #1; rst_n = 1'b1;
        step(b(OA),   8'h00, 1, 8'h00, "R1 A again");
        step(b(ORAM), 8'h00, 1, 8'hDD, "R11 RAM kept");
        step(b(EXT) | b(LMAR), 8'h01, 0, 0, "");
        step(b(ORAM), 8'h00, 1, 8'h33, "R11 RAM kept 1");
        step('0, 8'h00, 0, 0, "");
        @(posedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule